// File: doc/BRIEF.md
# FM Tuning Word Generator

This block converts a stream of signed audio modulation samples into 32-bit frequency tuning words for a direct digital synthesizer. Each accepted sample is scaled by a programmable peak-deviation constant, and a programmable carrier (center) word is added. The result is a tuning word that swings the synthesizer output around the carrier in proportion to the instantaneous modulation.

Two sample sources are supported and chosen per sample. In single-channel mode two 16-bit channels are each halved and summed, so the sum always fits in 16 bits. The deviation constant is therefore loaded at twice the nominal value to make up for the halving. In multiplex mode a ready-made 32-bit signed composite sample is used directly. The frequency word for a tone f at a 125 MHz synthesizer clock is f times 2^32 / 125e6, which is roughly 34.36 times f. A 34.7 MHz carrier is 0x4710CB29, and a 75 kHz swing is 0x00275254.

Top module: `fm_tuning_word_gen`

## Requirements
- R1: After reset `tw_valid` is 0 and `tw_word` is 0. The carrier register resets to 0x4710CB29 and the deviation register to 0x004EA4A8.
- R2: Every cycle with `in_valid` high yields exactly one one-cycle `tw_valid` pulse two clock edges later. Back-to-back samples give back-to-back pulses.
- R3: When `stereo_sel` is 0, the operand is formed from the two channels. Each of `left_in` and `right_in` is arithmetically shifted right by one. The two are then added into a 16-bit signed sum, which cannot overflow. That sum is placed in bits 31:16 of the 32-bit operand, with zeros below.
- R4: When `stereo_sel` is 1, `mpx_in` is the 32-bit two's-complement operand, and the channel inputs are ignored.
- R5: The frequency offset is bits 63:32 of the product of the signed operand and the unsigned 32-bit deviation register. This equals the product divided by 2^32 and rounded toward minus infinity.
- R6: `tw_word` = carrier register + offset, wrapping modulo 2^32.
- R7: A write strobe loads its register at the clock edge where it is high. A sample accepted at that same edge uses the earlier value. Samples already in flight are unaffected.
- R8: Between pulses `tw_word` holds the last word produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| stereo_sel | input | 1 | 0: two-channel mix, 1: composite sample |
| left_in | input | 16 | Signed first channel |
| right_in | input | 16 | Signed second channel |
| mpx_in | input | 32 | Signed composite sample |
| center_we | input | 1 | Load carrier register |
| center_wdata | input | 32 | New carrier word |
| dev_we | input | 1 | Load deviation register |
| dev_wdata | input | 32 | New deviation constant |
| tw_valid | output | 1 | One-cycle strobe for a new word |
| tw_word | output | 32 | Tuning word |

## Verification
The bench builds the block with its default parameters: a 0x4710CB29 carrier and a 0x004EA4A8 deviation, with 16-bit channels and 32-bit words. The reset values can therefore be read straight off a zero sample, and the 75 kHz composite constant is reached by a register write. Those values put the full-scale channel pair (0x7FFF and 0x8000) and the composite extremes within reach. A near-top carrier brings the modulo-2^32 wrap within reach, and a small negative composite sample exercises the floor rounding.

// File: rtl/fmtw_pkg.sv
package fmtw_pkg;
    localparam int AUD_W   = 16;
    localparam int WORD_W  = 32;
    localparam int ALIGN_W = WORD_W - AUD_W;
    localparam int PROD_W  = 2 * WORD_W + 1;

    localparam logic [WORD_W-1:0] CENTER_DEFAULT   = 32'h4710CB29;
    localparam logic [WORD_W-1:0] DEV_MONO_DEFAULT = 32'h004EA4A8;

    typedef logic signed [AUD_W-1:0] aud_t;
    typedef logic [WORD_W-1:0]        word_t;

    typedef enum logic {
        SRC_MIX = 1'b0,
        SRC_MPX = 1'b1
    } src_e;

    typedef struct packed {
        logic  vld;
        word_t operand;
        word_t dev;
        word_t center;
    } stage_t;

    function automatic aud_t mix_channels(aud_t a, aud_t b);
        aud_t ha;
        aud_t hb;
        ha = a >>> 1;
        hb = b >>> 1;
        return ha + hb;
    endfunction

    function automatic word_t align_mix(aud_t s);
        return {s, {ALIGN_W{1'b0}}};
    endfunction
endpackage

// File: rtl/fmtw_cfg_regs.sv
module fmtw_cfg_regs
    import fmtw_pkg::*;
#(
    parameter word_t CENTER_RST = CENTER_DEFAULT,
    parameter word_t DEV_RST    = DEV_MONO_DEFAULT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  center_we,
    input  word_t center_wdata,
    input  logic  dev_we,
    input  word_t dev_wdata,
    output word_t center_q,
    output word_t dev_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            center_q <= CENTER_RST;
            dev_q    <= DEV_RST;
        end else begin
            if (center_we) center_q <= center_wdata;
            if (dev_we)    dev_q    <= dev_wdata;
        end
    end
endmodule

// File: rtl/fmtw_operand_stage.sv
module fmtw_operand_stage
    import fmtw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  src_e   src,
    input  aud_t   left_in,
    input  aud_t   right_in,
    input  word_t  mpx_in,
    input  word_t  center_q,
    input  word_t  dev_q,
    output stage_t st_q
);
    word_t operand;

    always_comb begin
        unique case (src)
            SRC_MPX: operand = mpx_in;
            default: operand = align_mix(mix_channels(left_in, right_in));
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.vld <= in_valid;
            if (in_valid) begin
                st_q.operand <= operand;
                st_q.dev     <= dev_q;
                st_q.center  <= center_q;
            end
        end
    end
endmodule

// File: rtl/fmtw_scale_add.sv
module fmtw_scale_add
    import fmtw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stage_t st_i,
    output logic   tw_valid,
    output word_t  tw_word
);
    logic signed [PROD_W-1:0] op_ext;
    logic signed [PROD_W-1:0] dev_ext;
    logic signed [PROD_W-1:0] product;
    word_t                    offset;
    word_t                    sum;

    always_comb begin
        op_ext  = {{(PROD_W-WORD_W){st_i.operand[WORD_W-1]}}, st_i.operand};
        dev_ext = {{(PROD_W-WORD_W){1'b0}}, st_i.dev};
        product = op_ext * dev_ext;
        offset  = product[2*WORD_W-1:WORD_W];
        sum     = st_i.center + offset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tw_valid <= 1'b0;
            tw_word  <= '0;
        end else begin
            tw_valid <= st_i.vld;
            if (st_i.vld) tw_word <= sum;
        end
    end
endmodule

// File: rtl/fm_tuning_word_gen.sv
module fm_tuning_word_gen
    import fmtw_pkg::*;
#(
    parameter logic [31:0] CENTER_RST = CENTER_DEFAULT,
    parameter logic [31:0] DEV_RST    = DEV_MONO_DEFAULT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        stereo_sel,
    input  logic [15:0] left_in,
    input  logic [15:0] right_in,
    input  logic [31:0] mpx_in,
    input  logic        center_we,
    input  logic [31:0] center_wdata,
    input  logic        dev_we,
    input  logic [31:0] dev_wdata,
    output logic        tw_valid,
    output logic [31:0] tw_word
);
    word_t  center_q;
    word_t  dev_q;
    stage_t st;
    src_e   src;

    assign src = src_e'(stereo_sel);

    fmtw_cfg_regs #(
        .CENTER_RST(CENTER_RST),
        .DEV_RST   (DEV_RST)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .center_we   (center_we),
        .center_wdata(center_wdata),
        .dev_we      (dev_we),
        .dev_wdata   (dev_wdata),
        .center_q    (center_q),
        .dev_q       (dev_q)
    );

    fmtw_operand_stage u_opnd (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .src     (src),
        .left_in (aud_t'(left_in)),
        .right_in(aud_t'(right_in)),
        .mpx_in  (mpx_in),
        .center_q(center_q),
        .dev_q   (dev_q),
        .st_q    (st)
    );

    fmtw_scale_add u_mac (
        .clk     (clk),
        .rst     (rst),
        .st_i    (st),
        .tw_valid(tw_valid),
        .tw_word (tw_word)
    );
endmodule

// File: rtl/fmtw_checker.sv
module fmtw_checker
    import fmtw_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        stereo_sel,
    input logic [31:0] mpx_in,
    input logic        center_we,
    input logic [31:0] center_wdata,
    input logic        tw_valid,
    input logic [31:0] tw_word
);
    logic        v1, v2;
    logic        z1, z2;
    logic [31:0] cur_c, c1, c2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0; v2 <= 1'b0;
            z1 <= 1'b0; z2 <= 1'b0;
            cur_c <= CENTER_DEFAULT;
            c1 <= '0; c2 <= '0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            z1 <= in_valid && stereo_sel && (mpx_in == '0);
            z2 <= z1;
            c1 <= cur_c;
            c2 <= c1;
            if (center_we) cur_c <= center_wdata;
        end
    end

    // R1: reset clears the output side
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!tw_valid && tw_word == '0));

    // R2: strobe follows each sample by two edges
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        tw_valid == v2);

    // R8: word holds between strobes
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !tw_valid |-> $stable(tw_word));

    // R6 and R7: a zero composite sample returns the carrier in force when accepted
    assert_zero_center_R6: assert property (@(posedge clk) disable iff (rst)
        z2 |-> (tw_valid && tw_word == c2));
endmodule

bind fm_tuning_word_gen fmtw_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .stereo_sel  (stereo_sel),
    .mpx_in      (mpx_in),
    .center_we   (center_we),
    .center_wdata(center_wdata),
    .tw_valid    (tw_valid),
    .tw_word     (tw_word)
);

// File: tb/sim_fm_tuning_word_gen.sv
`timescale 1ns/1ps
module sim_fm_tuning_word_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        stereo_sel = 1'b0;
    logic [15:0] left_in = '0;
    logic [15:0] right_in = '0;
    logic [31:0] mpx_in = '0;
    logic        center_we = 1'b0;
    logic [31:0] center_wdata = '0;
    logic        dev_we = 1'b0;
    logic [31:0] dev_wdata = '0;
    logic        tw_valid;
    logic [31:0] tw_word;

    int checks = 0;
    int failures = 0;
    int neg_cnt = 0;
    bit done = 1'b0;
    logic [31:0] last_tw = '0;

    logic [31:0] m_center = 32'h4710CB29;
    logic [31:0] m_dev    = 32'h004EA4A8;

    typedef struct {
        logic [31:0] word;
        int          due;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;   // 250 MHz

    fm_tuning_word_gen u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .stereo_sel(stereo_sel),
        .left_in(left_in), .right_in(right_in), .mpx_in(mpx_in),
        .center_we(center_we), .center_wdata(center_wdata),
        .dev_we(dev_we), .dev_wdata(dev_wdata),
        .tw_valid(tw_valid), .tw_word(tw_word)
    );

    function automatic logic [31:0] ref_word(bit st, logic [15:0] l, logic [15:0] r,
                                             logic [31:0] m, logic [31:0] c, logic [31:0] d);
        longint x, dd, p;
        int     half_l, half_r, s;
        if (st) begin
            x = longint'($signed(m));
        end else begin
            half_l = int'($signed(l)) >>> 1;
            half_r = int'($signed(r)) >>> 1;
            s = half_l + half_r;
            x = longint'(s) * 65536;
        end
        dd = longint'({32'b0, d});
        p  = x * dd;
        return c + 32'(p >>> 32);
    endfunction

    task automatic cyc(bit v, bit st, logic [15:0] l, logic [15:0] r, logic [31:0] m,
                       bit wc, logic [31:0] cv, bit wd, logic [31:0] dv, string tag);
        exp_t e;
        @(negedge clk);
        #1;
        in_valid = v; stereo_sel = st; left_in = l; right_in = r; mpx_in = m;
        center_we = wc; center_wdata = cv; dev_we = wd; dev_wdata = dv;
        if (v) begin
            e.word = ref_word(st, l, r, m, m_center, m_dev);
            e.due  = neg_cnt + 2;
            e.tag  = tag;
            q.push_back(e);
        end
        if (wc) m_center = cv;
        if (wd) m_dev = dv;
    endtask

    task automatic samp(bit st, logic [15:0] l, logic [15:0] r, logic [31:0] m, string tag);
        cyc(1'b1, st, l, r, m, 1'b0, '0, 1'b0, '0, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, '0, '0, 1'b0, '0, 1'b0, '0, "");
    endtask

    // output monitor, sampled at the falling edge
    always @(negedge clk) begin
        neg_cnt++;
        if (!rst && !done) begin
            if (tw_valid) begin
                checks++;
                if (q.size() == 0) begin
                    failures++;
                    $display("FAIL R2 unexpected strobe got word %h exp no strobe", tw_word);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.due != neg_cnt) begin
                        failures++;
                        $display("FAIL R2 strobe timing got slot %0d exp %0d", neg_cnt, e.due);
                    end
                    if (tw_word !== e.word) begin
                        failures++;
                        $display("FAIL %s word got %h exp %h", e.tag, tw_word, e.word);
                    end
                end
            end else begin
                if (tw_word !== last_tw) begin
                    checks++;
                    failures++;
                    $display("FAIL R8 word moved without strobe got %h exp %h", tw_word, last_tw);
                end
                if (q.size() != 0 && q[0].due < neg_cnt) begin
                    checks++;
                    failures++;
                    $display("FAIL R2 missing strobe got none exp slot %0d", q[0].due);
                    void'(q.pop_front());
                end
            end
            last_tw = tw_word;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog got timeout exp completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        checks++;
        if (tw_valid !== 1'b0 || tw_word !== 32'h0) begin
            failures++;
            $display("FAIL R1 reset outputs got %b/%h exp 0/00000000", tw_valid, tw_word);
        end
        @(negedge clk); #1; rst = 1'b0;

        // R1 R6: zero samples expose reset carrier; R3 uses reset deviation
        samp(1'b0, 16'h0000, 16'h0000, '0, "R1");
        samp(1'b1, 16'h1234, 16'h4321, 32'h0, "R1");
        samp(1'b0, 16'h7FFF, 16'h7FFF, '0, "R3");
        samp(1'b0, 16'h8000, 16'h8000, '0, "R3");
        samp(1'b0, 16'h0001, 16'h0001, '0, "R3");   // each halves to 0
        samp(1'b0, 16'hFFFF, 16'h0001, '0, "R3");   // -1 + 0
        idle(3);

        // R4 R5: composite with 75 kHz constant
        cyc(1'b0, 1'b0, '0, '0, '0, 1'b0, '0, 1'b1, 32'h00275254, "");
        samp(1'b1, 16'h7FFF, 16'h7FFF, 32'h7FFFFFFF, "R4");
        samp(1'b1, 16'h0000, 16'h0000, 32'h80000000, "R4");
        samp(1'b1, 16'h0000, 16'h0000, 32'hFFFFFFFF, "R5");   // floor gives -1
        samp(1'b1, 16'h0000, 16'h0000, 32'h00000001, "R5");
        idle(2);

        // R6: wrap modulo 2^32
        cyc(1'b0, 1'b0, '0, '0, '0, 1'b1, 32'hFFFFFFF0, 1'b1, 32'hFFFFFFFF, "");
        samp(1'b1, '0, '0, 32'h7FFFFFFF, "R6");
        samp(1'b0, 16'h8000, 16'h8000, '0, "R6");
        idle(2);

        // R7: write coincident with a sample, and writes while samples are in flight
        cyc(1'b1, 1'b1, '0, '0, 32'h0, 1'b1, 32'h12345678, 1'b0, '0, "R7");
        cyc(1'b1, 1'b1, '0, '0, 32'h0, 1'b1, 32'hA5A5A5A5, 1'b1, 32'h00010000, "R7");
        cyc(1'b1, 1'b0, 16'h4000, 16'h2000, '0, 1'b0, '0, 1'b1, 32'h00000002, "R7");
        samp(1'b0, 16'h4000, 16'h2000, '0, "R7");
        idle(4);   // R8: output must hold across the gap

        // random mix of modes, gaps and configuration writes
        for (int i = 0; i < 400; i++) begin
            bit v, st, wc, wd;
            v  = ($urandom % 4) != 0;
            st = $urandom % 2;
            wc = ($urandom % 16) == 0;
            wd = ($urandom % 16) == 0;
            cyc(v, st, 16'($urandom), 16'($urandom), $urandom, wc, $urandom, wd, $urandom,
                st ? "R5" : "R3");
        end
        idle(5);

        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R2 pending words got %0d exp 0", q.size());
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule